// File: doc/BRIEF.md
# EPROM Signature Identification Sequencer

This block sits on the programmer side of an EPROM socket. Before a programming algorithm is chosen, the programmer has to learn what part sits in the socket. On a `start` pulse the sequencer turns on a flag that tells external circuitry to put the identification high voltage on address line A9. It holds every other address line low. With the chip selected and its outputs enabled, it then reads two identifier bytes: a manufacturer byte with A0 low and a device byte with A0 high.

The sequencer compares both bytes with the expected pair given on its input ports. It then releases the socket in a fixed order: output enable first, then chip enable, then the high-voltage flag. Only after that does it report the result together with a one-cycle `done` pulse. Two parameters set the wait times. One is the number of cycles the high voltage must settle before the first read. The other is the number of cycles the address and data must settle before each byte is captured.

Top module: `eprom_sig_reader`

## Requirements
- R1: Out of reset and while idle, `mem_ce_n` and `mem_oe_n` are 1, `hv_a9_en`, `done` and `busy` are 0, and `mem_addr` is all zeros.
- R2: A `start` pulse taken while idle raises `hv_a9_en` at once. `mem_ce_n` and `mem_oe_n` then stay 1 and `mem_addr` stays zero for exactly HV_SETTLE cycles before the first read cycle.
- R3: While either strobe is low, `hv_a9_en` is 1 and `mem_addr[ADDR_W-1:1]` is zero. `mem_oe_n` is low only while `mem_ce_n` is low.
- R4: The manufacturer byte is read with `mem_addr[0]`=0 and the device byte with `mem_addr[0]`=1. Both strobes stay low throughout, and each byte is captured from `mem_data` on all eight bits after ADDR_SETTLE read cycles. The captured bytes are held on `mfr_code` and `dev_code` until the next run.
- R5: `match` is 1 exactly when both captured bytes equal the `exp_mfr` and `exp_dev` values sampled with `start`. It is held until the next run.
- R6: Release order: `mem_oe_n` rises first while `mem_ce_n` stays low. `mem_ce_n` rises one cycle later. `hv_a9_en` falls one cycle after that. `done` follows one cycle later as a single-cycle pulse, HV_SETTLE+2*ADDR_SETTLE+3 clock edges after the edge that took `start`.
- R7: `start` while `busy` is 1 is ignored. The running sequence keeps its timing and results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin one identification run |
| exp_mfr | input | DATA_W | Expected manufacturer byte |
| exp_dev | input | DATA_W | Expected device byte |
| mem_data | input | DATA_W | Data outputs of the socketed part |
| mem_addr | output | ADDR_W | Address lines to the part |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| hv_a9_en | output | 1 | Request for the high voltage on A9 |
| mfr_code | output | DATA_W | Captured manufacturer byte |
| dev_code | output | DATA_W | Captured device byte |
| match | output | 1 | Both bytes equal the expected pair |
| done | output | 1 | One-cycle end-of-run pulse |
| busy | output | 1 | Run in progress |

## Verification
The assertions check the socket protocol on every cycle. A strobe is never low without the high voltage, or with upper address bits set. The high voltage is never turned on with a strobe low. The release order holds and `done` lasts one cycle. Only the bench's runs can show that the settle windows are long enough and that the right byte lands in each register. Its socket model returns garbage until the address and high voltage have been stable for the required cycles. The same is true of the match result against random and equal code pairs, the exact cycle of `done`, and the effect of a stray `start` in mid-run.

// File: rtl/eprom_sig_reader.sv
module eprom_sig_reader #(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int HV_SETTLE   = 6,
  parameter int ADDR_SETTLE = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] exp_mfr,
  input  logic [DATA_W-1:0] exp_dev,
  input  logic [DATA_W-1:0] mem_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              hv_a9_en,
  output logic [DATA_W-1:0] mfr_code,
  output logic [DATA_W-1:0] dev_code,
  output logic              match,
  output logic              done,
  output logic              busy
);
  localparam int MAXW = (HV_SETTLE > ADDR_SETTLE) ? HV_SETTLE : ADDR_SETTLE;
  localparam int CW   = $clog2(MAXW + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_HV, S_RD0, S_RD1, S_OFF_OE, S_OFF_CE, S_OFF_HV, S_DONE
  } state_t;

  state_t            state;
  logic [CW-1:0]     cnt;
  logic [DATA_W-1:0] exp_mfr_q, exp_dev_q;
  logic              last;

  always_comb begin
    case (state)
      S_HV:         last = (cnt == CW'(HV_SETTLE - 1));
      S_RD0, S_RD1: last = (cnt == CW'(ADDR_SETTLE - 1));
      default:      last = 1'b1;
    endcase
  end

  assign hv_a9_en = (state == S_HV) || (state == S_RD0) || (state == S_RD1) ||
                    (state == S_OFF_OE) || (state == S_OFF_CE);
  assign mem_ce_n = !((state == S_RD0) || (state == S_RD1) || (state == S_OFF_OE));
  assign mem_oe_n = !((state == S_RD0) || (state == S_RD1));
  assign mem_addr = {{(ADDR_W-1){1'b0}}, state == S_RD1};
  assign busy     = (state != S_IDLE);
  assign done     = (state == S_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      exp_mfr_q <= '0;
      exp_dev_q <= '0;
      mfr_code  <= '0;
      dev_code  <= '0;
      match     <= 1'b0;
    end else begin
      cnt <= last ? '0 : cnt + 1'b1;
      case (state)
        S_IDLE: begin
          cnt <= '0;
          if (start) begin
            state     <= S_HV;
            exp_mfr_q <= exp_mfr;
            exp_dev_q <= exp_dev;
            match     <= 1'b0;
          end
        end
        S_HV: if (last) state <= S_RD0;
        S_RD0: if (last) begin
          mfr_code <= mem_data;
          state    <= S_RD1;
        end
        S_RD1: if (last) begin
          dev_code <= mem_data;
          match    <= (mfr_code == exp_mfr_q) && (mem_data == exp_dev_q);
          state    <= S_OFF_OE;
        end
        S_OFF_OE: state <= S_OFF_CE;
        S_OFF_CE: state <= S_OFF_HV;
        S_OFF_HV: state <= S_DONE;
        default:  state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/eprom_sig_reader_chk.sv
module eprom_sig_reader_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_oe_n,
  input logic              hv_a9_en,
  input logic              done
);
  assert_read_needs_hv_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n || !mem_oe_n) |-> hv_a9_en);
  assert_upper_addr_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hv_a9_en |-> (mem_addr[ADDR_W-1:1] == '0));
  assert_oe_within_ce_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_ce_n);
  assert_hv_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hv_a9_en) |-> (mem_ce_n && mem_oe_n));
  assert_oe_off_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> (!mem_ce_n && hv_a9_en));
  assert_ce_off_next_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ce_n) |-> (mem_oe_n && hv_a9_en && $past(mem_oe_n == 1'b0 ? 1'b0 : 1'b1)));
  assert_hv_off_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hv_a9_en) |-> (mem_ce_n && mem_oe_n && !done));
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_after_hv_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(!hv_a9_en && busy));
  assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && start) |=> busy);
endmodule

bind eprom_sig_reader eprom_sig_reader_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .mem_addr(mem_addr),
  .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .hv_a9_en(hv_a9_en), .done(done)
);

// File: tb/eprom_sig_reader_tb.sv
module eprom_sig_reader_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 8;
  localparam int HV = 6;
  localparam int AS = 3;

  logic clk = 0, rst_n = 0, start = 0;
  logic [DW-1:0] exp_mfr = 0, exp_dev = 0, mem_data = 0;
  logic [AW-1:0] mem_addr;
  logic mem_ce_n, mem_oe_n, hv_a9_en, match, done, busy;
  logic [DW-1:0] mfr_code, dev_code;

  int checks = 0, failures = 0;
  logic [DW-1:0] ret_mfr = 8'h20, ret_dev = 8'h3D;
  int stab = 0, hvcnt = 0, pre_cnt = 0, pre_seen = -1;
  logic pce = 1, poe = 1, pa0 = 0, phv = 0;
  int viol = 0;
  int order_ph = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eprom_sig_reader #(.ADDR_W(AW), .DATA_W(DW), .HV_SETTLE(HV), .ADDR_SETTLE(AS)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .exp_mfr(exp_mfr), .exp_dev(exp_dev),
    .mem_data(mem_data), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .hv_a9_en(hv_a9_en), .mfr_code(mfr_code), .dev_code(dev_code), .match(match),
    .done(done), .busy(busy));

  function automatic logic exp_match(logic [7:0] rm, rd, em, ed);
    return (rm == em) && (rd == ed);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // socket model and protocol monitor, evaluated away from the active edge
  always @(negedge clk) begin
    logic sel;
    if ({mem_ce_n, mem_oe_n, mem_addr[0]} == {pce, poe, pa0}) stab++; else stab = 1;
    hvcnt = hv_a9_en ? hvcnt + 1 : 0;
    if (hv_a9_en && mem_ce_n && mem_oe_n && busy && !phv) pre_cnt = 0;
    if (hv_a9_en && mem_ce_n && mem_oe_n && pce) pre_cnt++;
    if (!mem_ce_n && pce) pre_seen = pre_cnt;
    if ((!mem_ce_n || !mem_oe_n) && (!hv_a9_en || mem_addr[AW-1:1] != 0)) viol++;
    if (!mem_oe_n && mem_ce_n) viol++;
    if (mem_oe_n && !poe && !(!mem_ce_n && hv_a9_en)) viol++;
    if (mem_ce_n && !pce && !(poe && hv_a9_en)) viol++;
    if (!hv_a9_en && phv && !(pce && mem_ce_n)) viol++;
    sel = !mem_ce_n && !mem_oe_n && hv_a9_en && stab >= AS && hvcnt >= HV + 1;
    if (sel) mem_data = mem_addr[0] ? ret_dev : ret_mfr;
    else     mem_data = ~(mem_addr[0] ? ret_dev : ret_mfr);
    pce = mem_ce_n; poe = mem_oe_n; pa0 = mem_addr[0]; phv = hv_a9_en;
  end

  task automatic run_one(logic [7:0] rm, rd, em, ed, bit poke);
    int n;
    int v0;
    ret_mfr = rm; ret_dev = rd;
    @(negedge clk);
    exp_mfr = em; exp_dev = ed; start = 1;
    v0 = viol; pre_seen = -1;
    @(posedge clk);
    @(negedge clk);
    start = 0; n = 1;
    exp_mfr = ~em; exp_dev = ~ed;
    chk("R2 hv raised", hv_a9_en, 1);
    chk("R2 strobes high", {mem_ce_n, mem_oe_n}, 2'b11);
    while (!done && n < 1000) begin
      if (poke && n == 3) start = 1;
      if (poke && n == HV + 2) start = 1;
      @(negedge clk);
      start = 0;
      n++;
    end
    chk("R6 done cycle", n, HV + 2*AS + 4);
    chk("R2 hv settle cycles", pre_seen, HV);
    chk("R4 mfr byte", mfr_code, rm);
    chk("R4 dev byte", dev_code, rd);
    chk("R5 match", match, exp_match(rm, rd, em, ed));
    chk("R3 R6 protocol", viol - v0, 0);
    @(negedge clk);
    chk("R6 done single", done, 0);
    chk("R7 idle after run", busy, 0);
    chk("R1 idle outputs", {mem_ce_n, mem_oe_n, hv_a9_en, mem_addr}, {3'b110, 16'h0});
  endtask

  initial begin
    void'($urandom(32'd2024));
    fork
      begin
        repeat (3) @(negedge clk);
        chk("R1 reset strobes", {mem_ce_n, mem_oe_n}, 2'b11);
        chk("R1 reset hv done busy", {hv_a9_en, done, busy}, 3'b000);
        chk("R1 reset addr", mem_addr, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);
        run_one(8'h20, 8'h3D, 8'h20, 8'h3D, 0);
        run_one(8'h20, 8'h3D, 8'h20, 8'h3E, 0);
        run_one(8'h21, 8'h3D, 8'h20, 8'h3D, 0);
        run_one(8'h20, 8'h3D, 8'h20, 8'h3D, 1);
        run_one(8'h00, 8'hFF, 8'h00, 8'hFF, 0);
        run_one(8'hFF, 8'h00, 8'hFF, 8'h01, 1);
        for (int i = 0; i < 20; i++) begin
          logic [7:0] rm, rd, em, ed;
          rm = 8'($urandom); rd = 8'($urandom);
          em = ($urandom % 2) ? rm : 8'($urandom);
          ed = ($urandom % 2) ? rd : 8'($urandom);
          run_one(rm, rd, em, ed, bit'($urandom % 2));
        end
      end
      begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule